// File: doc/BRIEF.md
# Inbound Request Ring Pointer Manager

This block sits on the device side of a host-to-device work queue held in host memory as a circular list of request descriptors. Each descriptor is 16 bytes: a 64-bit request address, a length counted in 32-bit words and a spare word. The host announces new work by writing a producer pointer register. The pointer carries a slot index plus a wrap-toggle bit, and the toggle inverts every time the index wraps from the last slot back to slot 0. Equal indices therefore mean an empty ring when the toggles agree and a full ring when they differ.

The block keeps a consumer pointer in the same format and compares it with the producer pointer to find the pending work. It hands out the next slot through a valid/ready pop port, together with the byte address of that slot's descriptor, computed from the ring base registers. A producer write that would overrun the ring is refused and raises a sticky error flag. An information register tells the host how many slots the ring has. A communication-reset input puts both pointers back to their start state, so that the first descriptor posted lands in slot 0.

Top module: `inbound_ring_mgr`

## Requirements
- R1: On `rst_n` low or `comm_reset` high at a clock edge, both pointers become index LIST_COUNT-1 with the toggle set, the ring reads empty and the error flag clears. The base registers reset to 0 on `rst_n` only.
- R2: The information register at byte offset 0x00 reads LIST_COUNT in bits [31:16], the sticky error in bit 0, empty in bit 1 and full in bit 2. All other bits read 0.
- R3: A write to the producer register at offset 0x0C is taken only when three conditions hold: its index is below LIST_COUNT, the occupancy it implies is at most LIST_COUNT, and that occupancy is not below the current occupancy. Any other write leaves the producer pointer unchanged and sets the error flag. Occupancy is (P − C) mod 2·LIST_COUNT, with each pointer's position being toggle·LIST_COUNT + index.
- R4: `ring_empty` is high when the producer and consumer match in both index and toggle. `ring_full` is high when the indices match and the toggles differ.
- R5: `pop_valid` is high exactly when the ring is not empty. `pop_slot` is the consumer index plus one, wrapping to 0 after LIST_COUNT-1.
- R6: A pop handshake (`pop_valid` and `pop_ready` high at an edge) moves the consumer one slot. An index that reaches LIST_COUNT becomes 0 and inverts the toggle. `pop_ready` while the ring is empty changes nothing.
- R7: The base registers at 0x04 (low word) and 0x08 (high word) read back what was written. `pop_entry_addr` equals {high, low} + 16·`pop_slot`.
- R8: The error flag stays set through later accepted writes and pops until R1 clears it.
- R9: The producer (0x0C) and consumer (0x10) registers read the index in bits [13:0] and the toggle in bit 14, with the other bits 0. Writes to the consumer register and to the information register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| comm_reset | input | 1 | Communication reset: re-initialise pointers and error |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset, shared by read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| pop_valid | output | 1 | A pending slot is offered |
| pop_ready | input | 1 | Consumer accepts the offered slot |
| pop_slot | output | 14 | Index of the offered slot |
| pop_entry_addr | output | 64 | Byte address of the offered descriptor |
| ring_empty | output | 1 | No pending slot |
| ring_full | output | 1 | Every slot pending |
| ovf_err | output | 1 | Sticky error from a refused producer write |

## Verification
The assertions assume that `comm_reset` is an isolated pulse. They also assume that every producer value the host writes either passes the R3 test or is refused, so the occupancy can never exceed the ring size. The pointer-wrap and pop-gating properties rely on `pop_ready` being ignored while the ring is empty. The stimulus lets a producer write and a pop share an edge only when the write keeps the occupancy at or above the current level. The sweep takes a ring of four slots and visits every consumer position across both toggle phases and every starting occupancy from empty to full. For each of those states it tries producer values in range, one past the end and at the top of the index field, and it rebuilds the state through a communication reset before each trial.

// File: rtl/ring_pkg.sv
// ring_pkg: register offsets and field positions shared by the ring manager.
// Assumes byte addressing of 32-bit registers.
package ring_pkg;
    localparam int PTR_IDX_W   = 14;   // index field width in pointer words
    localparam int PTR_TOG_BIT = 14;   // wrap-toggle position in pointer words
    localparam int INFO_CNT_LSB = 16;  // slot count field in info register
    localparam int ENTRY_SHIFT = 4;    // 16-byte descriptors

    localparam logic [7:0] OFS_INFO    = 8'h00;
    localparam logic [7:0] OFS_BASE_LO = 8'h04;
    localparam logic [7:0] OFS_BASE_HI = 8'h08;
    localparam logic [7:0] OFS_PROD    = 8'h0C;
    localparam logic [7:0] OFS_CONS    = 8'h10;
endpackage

// File: rtl/ring_step.sv
// ring_step: next pointer after advancing one slot with wrap-and-toggle.
// Assumes the input index is below LIST_COUNT.
module ring_step #(
    parameter int LIST_COUNT = 64,
    parameter int IW = 6
) (
    input  logic          in_tog,
    input  logic [IW-1:0] in_idx,
    output logic          out_tog,
    output logic [IW-1:0] out_idx
);
    localparam logic [IW-1:0] LAST = IW'(LIST_COUNT - 1);

    // Increment the index; at the last slot wrap to zero and flip the toggle.
    always_comb begin
        if (in_idx == LAST) begin
            out_idx = '0;
            out_tog = ~in_tog;
        end else begin
            out_idx = in_idx + 1'b1;
            out_tog = in_tog;
        end
    end
endmodule

// File: rtl/ring_level.sv
// ring_level: number of slots between a leading and a trailing pointer.
// Maps each pointer to a position toggle*N+index and subtracts modulo 2N.
// Assumes both indices are below LIST_COUNT.
module ring_level #(
    parameter int LIST_COUNT = 64,
    parameter int IW = 6,
    parameter int PW = 7
) (
    input  logic          lead_tog,
    input  logic [IW-1:0] lead_idx,
    input  logic          trail_tog,
    input  logic [IW-1:0] trail_idx,
    output logic [PW-1:0] occ
);
    localparam logic [PW-1:0] N_P  = PW'(LIST_COUNT);
    localparam logic [PW:0]   TWON = (PW+1)'(2 * LIST_COUNT);

    logic [PW-1:0] lead_pos;
    logic [PW-1:0] trail_pos;
    logic [PW:0]   diff;
    logic [PW:0]   wrapped;

    // Linear positions in [0, 2N).
    always_comb begin
        lead_pos  = lead_tog  ? (PW'(lead_idx)  + N_P) : PW'(lead_idx);
        trail_pos = trail_tog ? (PW'(trail_idx) + N_P) : PW'(trail_idx);
    end

    // Modular difference; add 2N back when the subtraction borrowed.
    always_comb begin
        diff    = {1'b0, lead_pos} - {1'b0, trail_pos};
        wrapped = diff + TWON;
        occ     = diff[PW] ? wrapped[PW-1:0] : diff[PW-1:0];
    end
endmodule

// File: rtl/ring_regs.sv
// ring_regs: host-visible register bank. Stores the ring base words,
// decodes producer writes and multiplexes read data.
// Assumes a single shared address for reads and writes.
module ring_regs #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [31:0]       info_word,
    input  logic [31:0]       prod_word,
    input  logic [31:0]       cons_word,
    output logic [31:0]       rdata,
    output logic              prod_wr,
    output logic [63:0]       base_addr
);
    import ring_pkg::*;

    localparam logic [ADDR_W-1:0] A_INFO = ADDR_W'(OFS_INFO);
    localparam logic [ADDR_W-1:0] A_BLO  = ADDR_W'(OFS_BASE_LO);
    localparam logic [ADDR_W-1:0] A_BHI  = ADDR_W'(OFS_BASE_HI);
    localparam logic [ADDR_W-1:0] A_PROD = ADDR_W'(OFS_PROD);
    localparam logic [ADDR_W-1:0] A_CONS = ADDR_W'(OFS_CONS);

    logic [31:0] base_lo_q;
    logic [31:0] base_hi_q;

    // Base address storage, cleared only by the chip reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
        end else if (wr_en) begin
            if (addr == A_BLO) base_lo_q <= wdata;
            if (addr == A_BHI) base_hi_q <= wdata;
        end
    end

    // Producer write strobe for the acceptance logic in the top.
    assign prod_wr   = wr_en && (addr == A_PROD);
    assign base_addr = {base_hi_q, base_lo_q};

    // Read multiplexer; unmapped offsets read zero.
    always_comb begin
        case (addr)
            A_INFO:  rdata = info_word;
            A_BLO:   rdata = base_lo_q;
            A_BHI:   rdata = base_hi_q;
            A_PROD:  rdata = prod_word;
            A_CONS:  rdata = cons_word;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/inbound_ring_mgr.sv
// inbound_ring_mgr: device-side tracker for a host-posted descriptor ring.
// The host moves the producer pointer by register write; the block refuses
// overruns, offers pending slots on a valid/ready pop port and advances its
// consumer pointer with the same wrap-and-toggle rule.
// Assumes 1 <= LIST_COUNT <= 16384 and ADDR_W >= 5.
module inbound_ring_mgr #(
    parameter int LIST_COUNT = 64,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              comm_reset,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              pop_valid,
    input  logic              pop_ready,
    output logic [13:0]       pop_slot,
    output logic [63:0]       pop_entry_addr,
    output logic              ring_empty,
    output logic              ring_full,
    output logic              ovf_err
);
    import ring_pkg::*;

    localparam int IW = (LIST_COUNT > 1) ? $clog2(LIST_COUNT) : 1;
    localparam int PW = IW + 1;
    localparam logic [IW-1:0] LAST = IW'(LIST_COUNT - 1);
    localparam logic [PW-1:0] N_P  = PW'(LIST_COUNT);

    logic          prod_tog, cons_tog;
    logic [IW-1:0] prod_idx, cons_idx;
    logic          err_q;

    logic          nxt_tog;
    logic [IW-1:0] nxt_idx;
    logic [PW-1:0] cur_occ, new_occ;
    logic          cand_tog, cand_in_range;
    logic [IW-1:0] cand_idx;
    logic          prod_wr, wr_accept, wr_refuse, pop_fire;
    logic [63:0]   base_addr;
    logic [31:0]   info_word, prod_word, cons_word;

    // Candidate producer value taken from the write data.
    always_comb begin
        cand_tog      = reg_wdata[PTR_TOG_BIT];
        cand_in_range = {1'b0, reg_wdata[PTR_IDX_W-1:0]} < 15'(LIST_COUNT);
        cand_idx      = reg_wdata[IW-1:0];
    end

    ring_step #(.LIST_COUNT(LIST_COUNT), .IW(IW)) u_step (
        .in_tog (cons_tog), .in_idx (cons_idx),
        .out_tog(nxt_tog),  .out_idx(nxt_idx)
    );

    ring_level #(.LIST_COUNT(LIST_COUNT), .IW(IW), .PW(PW)) u_cur (
        .lead_tog (prod_tog), .lead_idx (prod_idx),
        .trail_tog(cons_tog), .trail_idx(cons_idx),
        .occ      (cur_occ)
    );

    ring_level #(.LIST_COUNT(LIST_COUNT), .IW(IW), .PW(PW)) u_new (
        .lead_tog (cand_tog), .lead_idx (cand_idx),
        .trail_tog(cons_tog), .trail_idx(cons_idx),
        .occ      (new_occ)
    );

    ring_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .info_word(info_word),
        .prod_word(prod_word),
        .cons_word(cons_word),
        .rdata    (reg_rdata),
        .prod_wr  (prod_wr),
        .base_addr(base_addr)
    );

    // Status and handshake decode.
    always_comb begin
        ring_empty = (cur_occ == '0);
        ring_full  = (cur_occ == N_P);
        pop_valid  = !ring_empty;
        pop_fire   = pop_valid && pop_ready;
        wr_accept  = prod_wr && cand_in_range && (new_occ <= N_P) && (new_occ >= cur_occ);
        wr_refuse  = prod_wr && !wr_accept;
    end

    // Pointer and error state; comm_reset re-initialises like rst_n.
    always_ff @(posedge clk) begin
        if (!rst_n || comm_reset) begin
            prod_tog <= 1'b1;
            prod_idx <= LAST;
            cons_tog <= 1'b1;
            cons_idx <= LAST;
            err_q    <= 1'b0;
        end else begin
            if (wr_accept) begin
                prod_tog <= cand_tog;
                prod_idx <= cand_idx;
            end
            if (pop_fire) begin
                cons_tog <= nxt_tog;
                cons_idx <= nxt_idx;
            end
            if (wr_refuse) err_q <= 1'b1;
        end
    end

    // Register-format words for readback.
    always_comb begin
        prod_word = '0;
        prod_word[IW-1:0]   = prod_idx;
        prod_word[PTR_TOG_BIT] = prod_tog;
        cons_word = '0;
        cons_word[IW-1:0]   = cons_idx;
        cons_word[PTR_TOG_BIT] = cons_tog;
        info_word = '0;
        info_word[31:INFO_CNT_LSB] = 16'(LIST_COUNT);
        info_word[2:0] = {ring_full, ring_empty, err_q};
    end

    // Offered slot and the byte address of its descriptor.
    always_comb begin
        pop_slot = '0;
        pop_slot[IW-1:0] = nxt_idx;
        pop_entry_addr = base_addr + (64'(nxt_idx) << ENTRY_SHIFT);
    end

    assign ovf_err = err_q;
endmodule

// File: rtl/ring_checker.sv
// ring_checker: temporal properties of the ring manager, bound to the top.
// Assumes comm_reset pulses are isolated and pop_ready is free-running.
module ring_checker #(
    parameter int LIST_COUNT = 64,
    parameter int IW = 6,
    parameter int PW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          comm_reset,
    input logic          pop_valid,
    input logic          pop_ready,
    input logic          ring_empty,
    input logic          ring_full,
    input logic          ovf_err,
    input logic          prod_tog,
    input logic [IW-1:0] prod_idx,
    input logic          cons_tog,
    input logic [IW-1:0] cons_idx,
    input logic [PW-1:0] cur_occ
);
    localparam logic [IW-1:0] LAST = IW'(LIST_COUNT - 1);

    // R1: communication reset lands both pointers on the start slot.
    p_ptr_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
        comm_reset |=> (cons_idx == LAST && cons_tog && prod_idx == LAST && prod_tog && !ovf_err));

    // R3: occupancy never exceeds the ring size.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cur_occ <= PW'(LIST_COUNT));

    // R4: full means equal indices with opposite toggles.
    p_full_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ring_full |-> (prod_idx == cons_idx && prod_tog != cons_tog));

    // R6: ready on an empty ring leaves the consumer in place.
    p_pop_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ready && ring_empty && !comm_reset) |=> ($stable(cons_idx) && $stable(cons_tog)));

    // R6: popping the last slot wraps to zero and flips the toggle.
    p_toggle_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && pop_ready && cons_idx == LAST && !comm_reset)
        |=> (cons_idx == '0 && cons_tog != $past(cons_tog)));

    // R8: the error flag holds until a communication reset.
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err && !comm_reset) |=> ovf_err);
endmodule

bind inbound_ring_mgr ring_checker #(.LIST_COUNT(LIST_COUNT), .IW(IW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .comm_reset(comm_reset),
    .pop_valid (pop_valid),
    .pop_ready (pop_ready),
    .ring_empty(ring_empty),
    .ring_full (ring_full),
    .ovf_err   (ovf_err),
    .prod_tog  (prod_tog),
    .prod_idx  (prod_idx),
    .cons_tog  (cons_tog),
    .cons_idx  (cons_idx),
    .cur_occ   (cur_occ)
);

// File: tb/sim_inbound_ring_mgr.sv
// sim_inbound_ring_mgr: sweeps every consumer position, starting occupancy
// and a set of producer candidates on a four-slot ring.
module sim_inbound_ring_mgr;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam logic [4:0] A_INFO = 5'h00, A_BLO = 5'h04, A_BHI = 5'h08,
                           A_PROD = 5'h0C, A_CONS = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        comm_reset = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pop_valid;
    logic        pop_ready = 1'b0;
    logic [13:0] pop_slot;
    logic [63:0] pop_entry_addr;
    logic        ring_empty, ring_full, ovf_err;

    int checks = 0;
    int failures = 0;

    inbound_ring_mgr #(.LIST_COUNT(N), .ADDR_W(5)) u0 (
        .clk(clk), .rst_n(rst_n), .comm_reset(comm_reset),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pop_valid(pop_valid), .pop_ready(pop_ready),
        .pop_slot(pop_slot), .pop_entry_addr(pop_entry_addr),
        .ring_empty(ring_empty), .ring_full(ring_full), .ovf_err(ovf_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ptr_word(input int pos);
        return ((pos >= N) ? 32'h4000 : 32'h0) | 32'(pos % N);
    endfunction

    function automatic int occ_of(input int p, input int c);
        return (p - c + 2*N) % (2*N);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pop1;
        @(negedge clk);
        pop_ready = 1'b1;
        @(negedge clk);
        pop_ready = 1'b0;
    endtask

    task automatic creset;
        @(negedge clk);
        comm_reset = 1'b1;
        @(negedge clk);
        comm_reset = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cpos;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2 / R9: reset state.
        rd(A_PROD, d); check(d == 32'h4003, "R1 prod after reset", d, 32'h4003);
        rd(A_CONS, d); check(d == 32'h4003, "R1 cons after reset", d, 32'h4003);
        rd(A_INFO, d); check(d == 32'h0004_0002, "R2 info after reset", d, 32'h0004_0002);
        check(pop_valid == 1'b0, "R5 no pop when empty", pop_valid, 0);

        // R7: base registers and descriptor address.
        wr(A_BLO, 32'hDEAD_B000);
        wr(A_BHI, 32'h0000_0012);
        rd(A_BLO, d); check(d == 32'hDEAD_B000, "R7 base lo", d, 32'hDEAD_B000);
        rd(A_BHI, d); check(d == 32'h12, "R7 base hi", d, 32'h12);

        // R9: consumer and info registers ignore writes.
        wr(A_CONS, 32'h0000_0001);
        rd(A_CONS, d); check(d == 32'h4003, "R9 cons write ignored", d, 32'h4003);
        wr(A_INFO, 32'hFFFF_FFFF);
        rd(A_INFO, d); check(d == 32'h0004_0002, "R9 info write ignored", d, 32'h0004_0002);

        // R4 / R5 / R6 / R7: fill the ring, then drain across the wrap.
        wr(A_PROD, ptr_word(3));
        check(ring_full == 1'b1, "R4 full", ring_full, 1);
        rd(A_INFO, d); check(d[2:0] == 3'b100, "R2 full bit", d[2:0], 3'b100);
        for (int i = 0; i < N; i++) begin
            check(pop_valid && pop_slot == 14'(i), "R5 drain slot", pop_slot, i);
            check(pop_entry_addr == 64'h12_DEAD_B000 + 64'(16*i), "R7 entry addr",
                  pop_entry_addr, 64'h12_DEAD_B000 + 64'(16*i));
            pop1();
        end
        check(ring_empty == 1'b1, "R4 empty after drain", ring_empty, 1);
        pop1();
        rd(A_CONS, d); check(d == 32'h0003, "R6 pop on empty ignored", d, 32'h0003);
        wr(A_PROD, ptr_word(5));
        pop1(); pop1();
        rd(A_CONS, d); check(d == 32'h4001, "R6 wrap toggles consumer", d, 32'h4001);

        // R6 / R3: write and pop on the same edge.
        wr(A_PROD, ptr_word(6));
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = A_PROD; reg_wdata = ptr_word(7); pop_ready = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; pop_ready = 1'b0;
        rd(A_PROD, d); check(d == ptr_word(7), "R3 write with pop", d, ptr_word(7));
        rd(A_CONS, d); check(d == ptr_word(6), "R6 pop with write", d, ptr_word(6));

        // R8: sticky error across an accepted write and a pop.
        wr(A_PROD, 32'h0000_3FFF);
        check(ovf_err == 1'b1, "R3 out-of-range refused", ovf_err, 1);
        wr(A_PROD, ptr_word(0));
        pop1();
        check(ovf_err == 1'b1, "R8 error stays set", ovf_err, 1);
        rd(A_PROD, d); check(d == ptr_word(0), "R8 later write accepted", d, ptr_word(0));
        creset();
        check(ovf_err == 1'b0, "R1 comm reset clears error", ovf_err, 0);
        rd(A_CONS, d); check(d == 32'h4003, "R1 comm reset cons", d, 32'h4003);
        rd(A_BLO, d); check(d == 32'hDEAD_B000, "R1 base kept on comm reset", d, 32'hDEAD_B000);

        // R3 / R4 / R5 sweep: consumer position c, occupancy m, candidate word.
        for (int c = 0; c < 2*N; c++) begin
            for (int m = 0; m <= N; m++) begin
                for (int k = 0; k < 2*(N+2) + 1; k++) begin
                    int ct, ci, exp_occ, exp_ppos;
                    bit ok_wr;
                    logic [31:0] cand;
                    creset();
                    cpos = 2*N - 1;
                    while (cpos != c) begin
                        wr(A_PROD, ptr_word((cpos + 1) % (2*N)));
                        pop1();
                        cpos = (cpos + 1) % (2*N);
                    end
                    wr(A_PROD, ptr_word((c + m) % (2*N)));
                    if (k == 2*(N+2)) begin ct = 1; ci = 14'h3FFF; end
                    else begin ct = k / (N+2); ci = k % (N+2); end
                    cand = (ct != 0 ? 32'h4000 : 32'h0) | 32'(ci);
                    ok_wr = (ci < N) && (occ_of(ct*N + ci, c) <= N) && (occ_of(ct*N + ci, c) >= m);
                    exp_ppos = ok_wr ? (ct*N + ci) : (c + m) % (2*N);
                    exp_occ = occ_of(exp_ppos, c);
                    wr(A_PROD, cand);
                    rd(A_PROD, d);
                    check(d == ptr_word(exp_ppos), "R3 sweep producer", d, ptr_word(exp_ppos));
                    check(ovf_err == !ok_wr, "R3 sweep error flag", ovf_err, !ok_wr);
                    check(ring_empty == (exp_occ == 0) && ring_full == (exp_occ == N),
                          "R4 sweep empty/full", {ring_full, ring_empty},
                          {exp_occ == N, exp_occ == 0});
                    check(pop_valid == (exp_occ != 0) && pop_slot == 14'((c + 1) % N),
                          "R5 sweep pop port", {pop_valid, pop_slot},
                          {exp_occ != 0, 14'((c + 1) % N)});
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule